// File: doc/BRIEF.md
# Three-Bus Microcoded Datapath

A 32-bit execution datapath driven directly by a wide, already-decoded control word that is presented anew on every clock. Each cycle, two register-file read ports place operands on the X and Y buses. The Y bus can instead carry a sign-extended 16-bit literal from the control word. One of four sources then drives the Z bus: an adder/subtractor, a bitwise logic unit programmed by a 4-bit truth table, a barrel shifter, or a load from a small word-addressed data memory. The Z bus can be written back into any register at the rising edge.

The control word is meant to come from a sequencer outside this block, one microinstruction per cycle. The X, Y and Z buses are brought out as outputs, so the sequencer and the test environment can observe operands and results. A store writes the Y bus value into the data memory word addressed by the low bits of the X bus.

Top module: `tribus_datapath`

## Requirements
- R1: While `rst_n` is low, every register and every data memory word is cleared to zero at the clock edge. After reset, every register reads zero on the X bus.
- R2: `x_bus` equals register `x_sel`. `y_bus` equals register `y_sel`, unless `imm_en` is 1, in which case it equals `imm_val` sign-extended from bit 15 to 32 bits.
- R3: With only `arith_en` set, `z_bus` is `x_bus + y_bus` when `arith_sub` is 0 and `x_bus - y_bus` when `arith_sub` is 1, modulo 2^32.
- R4: With only `logic_en` set, each bit i of `z_bus` equals `logic_fn[{x_bus[i], y_bus[i]}]`. This means X=0,Y=0 selects bit 0, X=0,Y=1 selects bit 1, X=1,Y=0 selects bit 2, and X=1,Y=1 selects bit 3.
- R5: With only `shift_en` set, the shift distance is `y_bus[4:0]` read as a signed value from -16 to 15. A non-negative distance shifts `x_bus` left by that many bits, and a negative distance shifts it right by the magnitude. `shift_kind` 0 (logical) and 3 (treated as logical) fill vacated bits with zero.
- R6: `shift_kind` 1 (arithmetic) fills bits vacated by a right shift with copies of `x_bus[31]`. A left shift under this kind is identical to a logical left shift.
- R7: `shift_kind` 2 (rotate) rotates `x_bus` within 32 bits. A distance d rotates left by d, or right by -d when d is negative, so no bit is lost.
- R8: At a rising edge with `reg_we` 1, register `z_sel` takes the value of `z_bus`. With `reg_we` 0, no register changes. A read of the register being written returns the old value until that edge.
- R9: When none of `arith_en`, `logic_en`, `shift_en` and `load_en` is set, or when more than one is set, `z_bus` is zero, and a write-back in that cycle stores zero.
- R10: At a rising edge with `mem_sel` 1, `mem_rd` 0 and `store_en` 1, the data word at address `x_bus[MEM_AW-1:0]` takes `y_bus`. If any of these three conditions is missing, no memory word changes.
- R11: With only `load_en` set, `z_bus` equals the data word at address `x_bus[MEM_AW-1:0]` when `mem_sel` is 1 and `mem_rd` is 1. If either of those two is 0, `z_bus` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| x_sel | input | 5 | Register read onto the X bus |
| y_sel | input | 5 | Register read onto the Y bus |
| z_sel | input | 5 | Register written from the Z bus |
| reg_we | input | 1 | Register write enable |
| imm_en | input | 1 | Put the literal on the Y bus instead of a register |
| imm_val | input | 16 | Signed literal |
| arith_en | input | 1 | Adder/subtractor drives the Z bus |
| arith_sub | input | 1 | 0 selects add, 1 selects subtract |
| logic_en | input | 1 | Logic unit drives the Z bus |
| logic_fn | input | 4 | Truth table of the logic unit |
| shift_en | input | 1 | Shifter drives the Z bus |
| shift_kind | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 logical |
| load_en | input | 1 | Memory read data drives the Z bus |
| store_en | input | 1 | Y bus is offered as memory write data |
| mem_rd | input | 1 | 1 read, 0 write |
| mem_sel | input | 1 | Memory access enable |
| x_bus | output | 32 | X operand |
| y_bus | output | 32 | Y operand |
| z_bus | output | 32 | Result bus |

## Verification
A corrupt register entry appears on `x_bus` or `y_bus` as soon as that register is selected. It reaches `z_bus` in the same cycle, because every unit is combinational from the buses. A write-back fault, such as a wrong target, a missing enable or an early write, shows on `x_bus` one cycle after the faulty edge, when the target register is read back. A wrong memory word stays hidden until a later load of that address puts it on `z_bus`. For that reason, every store in the tests is followed directly by a load of the same address and by a load of an address that must not have changed.

// File: rtl/tribus_datapath.sv
module tribus_datapath #(
  parameter int DW     = 32,
  parameter int RN     = 32,
  parameter int IW     = 16,
  parameter int MEM_AW = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [$clog2(RN)-1:0]  x_sel,
  input  logic [$clog2(RN)-1:0]  y_sel,
  input  logic [$clog2(RN)-1:0]  z_sel,
  input  logic                   reg_we,
  input  logic                   imm_en,
  input  logic [IW-1:0]          imm_val,
  input  logic                   arith_en,
  input  logic                   arith_sub,
  input  logic                   logic_en,
  input  logic [3:0]             logic_fn,
  input  logic                   shift_en,
  input  logic [1:0]             shift_kind,
  input  logic                   load_en,
  input  logic                   store_en,
  input  logic                   mem_rd,
  input  logic                   mem_sel,
  output logic [DW-1:0]          x_bus,
  output logic [DW-1:0]          y_bus,
  output logic [DW-1:0]          z_bus
);
  localparam int SW    = $clog2(DW);
  localparam int MDEP  = 1 << MEM_AW;

  logic [DW-1:0] rf  [RN];
  logic [DW-1:0] dmem [MDEP];

  assign x_bus = rf[x_sel];
  assign y_bus = imm_en ? {{(DW-IW){imm_val[IW-1]}}, imm_val} : rf[y_sel];

  logic [DW-1:0] arith_res;
  assign arith_res = arith_sub ? x_bus - y_bus : x_bus + y_bus;

  logic [DW-1:0] logic_res;
  for (genvar i = 0; i < DW; i++) begin : g_lu
    assign logic_res[i] = logic_fn[{x_bus[i], y_bus[i]}];
  end

  logic [SW-1:0] sh_amt, sh_mag;
  logic          sh_left;
  logic [DW-1:0] sh_res, rot_res;
  assign sh_amt  = y_bus[SW-1:0];
  assign sh_left = ~sh_amt[SW-1];
  assign sh_mag  = sh_left ? sh_amt : (~sh_amt + 1'b1);
  assign rot_res = (x_bus << sh_amt) | (x_bus >> ((SW+1)'(DW) - {1'b0, sh_amt}));

  always_comb begin
    case (shift_kind)
      2'd1:    sh_res = sh_left ? (x_bus << sh_mag) : DW'($signed(x_bus) >>> sh_mag);
      2'd2:    sh_res = rot_res;
      default: sh_res = sh_left ? (x_bus << sh_mag) : (x_bus >> sh_mag);
    endcase
  end

  logic [MEM_AW-1:0] maddr;
  logic [DW-1:0]     load_res;
  logic              do_store;
  assign maddr    = x_bus[MEM_AW-1:0];
  assign load_res = (mem_sel && mem_rd) ? dmem[maddr] : '0;
  assign do_store = mem_sel && !mem_rd && store_en;

  logic [3:0] srcs;
  assign srcs = {arith_en, logic_en, shift_en, load_en};

  always_comb begin
    unique case (srcs)
      4'b1000: z_bus = arith_res;
      4'b0100: z_bus = logic_res;
      4'b0010: z_bus = sh_res;
      4'b0001: z_bus = load_res;
      default: z_bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RN; i++) rf[i] <= '0;
    end else if (reg_we) begin
      rf[z_sel] <= z_bus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MDEP; i++) dmem[i] <= '0;
    end else if (do_store) begin
      dmem[maddr] <= y_bus;
    end
  end
endmodule

// File: rtl/tribus_datapath_chk.sv
module tribus_datapath_chk #(
  parameter int DW     = 32,
  parameter int RN     = 32,
  parameter int IW     = 16,
  parameter int MEM_AW = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [$clog2(RN)-1:0]  x_sel,
  input logic [$clog2(RN)-1:0]  y_sel,
  input logic [$clog2(RN)-1:0]  z_sel,
  input logic                   reg_we,
  input logic                   imm_en,
  input logic [IW-1:0]          imm_val,
  input logic                   arith_en,
  input logic                   arith_sub,
  input logic                   logic_en,
  input logic [3:0]             logic_fn,
  input logic                   shift_en,
  input logic [1:0]             shift_kind,
  input logic                   load_en,
  input logic                   store_en,
  input logic                   mem_rd,
  input logic                   mem_sel,
  input logic [DW-1:0]          x_bus,
  input logic [DW-1:0]          y_bus,
  input logic [DW-1:0]          z_bus
);
  logic only_arith, only_logic, only_load, stored;
  assign only_arith = arith_en && !logic_en && !shift_en && !load_en;
  assign only_logic = logic_en && !arith_en && !shift_en && !load_en;
  assign only_load  = load_en && !arith_en && !logic_en && !shift_en;
  assign stored     = mem_sel && !mem_rd && store_en;

  // R2
  imm_on_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_en |-> (y_bus == {{(DW-IW){imm_val[IW-1]}}, imm_val}));

  // R3
  arith_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_arith |-> (z_bus == (arith_sub ? x_bus - y_bus : x_bus + y_bus)));

  // R4
  logic_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_logic |-> (z_bus[0] == logic_fn[{x_bus[0], y_bus[0]}]));

  // R9
  z_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({arith_en, logic_en, shift_en, load_en}) != 1) |-> (z_bus == '0));

  // R8
  writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (x_sel != $past(z_sel) || x_bus == $past(z_bus)));

  // R10
  store_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stored |=> (!(only_load && mem_sel && mem_rd && x_bus[MEM_AW-1:0] == $past(x_bus[MEM_AW-1:0]))
                || z_bus == $past(y_bus)));
endmodule

bind tribus_datapath tribus_datapath_chk #(.DW(DW), .RN(RN), .IW(IW), .MEM_AW(MEM_AW)) chk_i (.*);

// File: tb/tribus_datapath_tb.sv
module tribus_datapath_tb_top;
  logic clk = 0, rst_n = 0;
  logic [4:0] x_sel, y_sel, z_sel;
  logic reg_we, imm_en, arith_en, arith_sub, logic_en, shift_en, load_en, store_en, mem_rd, mem_sel;
  logic [15:0] imm_val;
  logic [3:0] logic_fn;
  logic [1:0] shift_kind;
  logic [31:0] x_bus, y_bus, z_bus;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tribus_datapath dut_i (.*);

  // vector: xs, ys, imm_en, imm, unit(0 arith,1 logic,2 shift), fn, expected z
  localparam int NV = 18;
  localparam logic [64:0] VECS [NV] = '{
    {5'd1, 5'd2, 1'b0, 16'h0000, 2'd0, 4'h0, 32'h0000006B},
    {5'd1, 5'd2, 1'b0, 16'h0000, 2'd0, 4'h1, 32'h0000005D},
    {5'd2, 5'd1, 1'b0, 16'h0000, 2'd0, 4'h1, 32'hFFFFFFA3},
    {5'd1, 5'd0, 1'b1, 16'hFFFF, 2'd0, 4'h0, 32'h00000063},
    {5'd4, 5'd1, 1'b0, 16'h0000, 2'd1, 4'h8, 32'h00000040},
    {5'd4, 5'd1, 1'b0, 16'h0000, 2'd1, 4'h6, 32'h00005A3E},
    {5'd2, 5'd2, 1'b0, 16'h0000, 2'd1, 4'h1, 32'hFFFFFFF8},
    {5'd5, 5'd1, 1'b0, 16'h0000, 2'd1, 4'hC, 32'hFFFF8000},
    {5'd2, 5'd0, 1'b1, 16'h0004, 2'd2, 4'h0, 32'h00000070},
    {5'd5, 5'd0, 1'b1, 16'hFFFC, 2'd2, 4'h0, 32'h0FFFF800},
    {5'd5, 5'd0, 1'b1, 16'hFFFC, 2'd2, 4'h1, 32'hFFFFF800},
    {5'd1, 5'd0, 1'b1, 16'hFFFE, 2'd2, 4'h1, 32'h00000019},
    {5'd5, 5'd0, 1'b1, 16'h0004, 2'd2, 4'h2, 32'hFFF8000F},
    {5'd2, 5'd0, 1'b1, 16'h001F, 2'd2, 4'h2, 32'h80000003},
    {5'd1, 5'd2, 1'b0, 16'h0000, 2'd2, 4'h0, 32'h00003200},
    {5'd1, 5'd0, 1'b1, 16'h000F, 2'd2, 4'h0, 32'h00320000},
    {5'd5, 5'd0, 1'b1, 16'h0010, 2'd2, 4'h0, 32'h0000FFFF},
    {5'd2, 5'd0, 1'b1, 16'h0004, 2'd2, 4'h3, 32'h00000070}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    {x_sel, y_sel, z_sel} = '0;
    {reg_we, imm_en, arith_en, arith_sub, logic_en, shift_en, load_en, store_en, mem_rd, mem_sel} = '0;
    imm_val = '0; logic_fn = '0; shift_kind = '0;
  endtask

  task automatic put_imm(input logic [4:0] r, input logic [15:0] v);
    @(negedge clk); idle();
    imm_en = 1; imm_val = v; arith_en = 1; reg_we = 1; z_sel = r;
    @(posedge clk);
  endtask

  task automatic read_x(input logic [4:0] r, output logic [31:0] v);
    @(negedge clk); idle(); x_sel = r; #2 v = x_bus;
  endtask

  initial begin
    logic [31:0] v;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: registers are zero after reset
    for (int r = 0; r < 32; r++) begin
      read_x(r[4:0], v); chk("R1 reg clear", v, 32'h0);
    end
    put_imm(5'd1, 16'd100);
    put_imm(5'd2, 16'd7);
    put_imm(5'd3, 16'hFFF8);
    put_imm(5'd4, 16'h5A5A);
    put_imm(5'd5, 16'h8000);
    // R2: register and sign-extended immediate on the buses
    @(negedge clk); idle(); x_sel = 3; y_sel = 5; #2
    chk("R2 x reg", x_bus, 32'hFFFFFFF8);
    chk("R2 y reg", y_bus, 32'hFFFF8000);
    imm_en = 1; imm_val = 16'h7FFF; #1 chk("R2 y imm", y_bus, 32'h00007FFF);

    // R3 R4 R5 R6 R7 vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); idle();
      x_sel = VECS[i][64:60]; y_sel = VECS[i][59:55];
      imm_en = VECS[i][54]; imm_val = VECS[i][53:38];
      case (VECS[i][37:36])
        2'd0: begin arith_en = 1; arith_sub = VECS[i][32]; end
        2'd1: begin logic_en = 1; logic_fn = VECS[i][35:32]; end
        default: begin shift_en = 1; shift_kind = VECS[i][33:32]; end
      endcase
      #2 chk($sformatf("R3/R4/R5/R6/R7 vec %0d", i), z_bus, VECS[i][31:0]);
    end

    // R8: write-back, old value visible until the edge
    @(negedge clk); idle();
    x_sel = 6; imm_en = 1; imm_val = 16'h0123; arith_en = 1; reg_we = 1; z_sel = 6;
    #2 chk("R8 old value same cycle", x_bus, 32'h0);
    read_x(5'd6, v); chk("R8 written", v, 32'h00000123);
    @(negedge clk); idle();
    imm_en = 1; imm_val = 16'h0999; arith_en = 1; reg_we = 0; z_sel = 6;
    read_x(5'd6, v); chk("R8 no write when disabled", v, 32'h00000123);

    // R9: no source and conflicting sources
    @(negedge clk); idle(); x_sel = 1; y_sel = 2; #2 chk("R9 no source", z_bus, 32'h0);
    arith_en = 1; logic_en = 1; logic_fn = 4'hF; #1 chk("R9 conflict", z_bus, 32'h0);
    reg_we = 1; z_sel = 6;
    read_x(5'd6, v); chk("R9 conflict writes zero", v, 32'h0);

    // R10 R11: store then load
    @(negedge clk); idle(); x_sel = 1; y_sel = 4; mem_sel = 1; store_en = 1;
    @(negedge clk); idle(); x_sel = 1; mem_sel = 1; mem_rd = 1; load_en = 1;
    #2 chk("R10/R11 load stored word", z_bus, 32'h00005A5A);
    mem_sel = 0; #1 chk("R11 load without select", z_bus, 32'h0);
    mem_sel = 1; mem_rd = 0; #1 chk("R11 load without read", z_bus, 32'h0);
    @(negedge clk); idle(); x_sel = 2; y_sel = 5; store_en = 1; mem_sel = 0;
    @(negedge clk); idle(); x_sel = 2; y_sel = 5; store_en = 1; mem_sel = 1; mem_rd = 1;
    @(negedge clk); idle(); x_sel = 2; y_sel = 5; store_en = 0; mem_sel = 1;
    @(negedge clk); idle(); x_sel = 2; mem_sel = 1; mem_rd = 1; load_en = 1;
    #2 chk("R10 blocked stores leave word", z_bus, 32'h0);

    // R1: reset in mid-run clears registers and memory
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1;
    read_x(5'd4, v); chk("R1 reg cleared again", v, 32'h0);
    @(negedge clk); idle(); imm_en = 1; imm_val = 16'd36; x_sel = 0; y_sel = 0;
    // address 36 via r7
    arith_en = 1; reg_we = 1; z_sel = 7;
    @(negedge clk); idle(); x_sel = 7; mem_sel = 1; mem_rd = 1; load_en = 1;
    #2 chk("R1 memory cleared", z_bus, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule